// File: doc/BRIEF.md
# Receive Inactivity Timeout Watchdog

This block watches an input data port and raises a timeout when no data word has arrived for a programmed interval. A prescaler divides the bus clock by a fixed ratio of 33. With a 33 MHz bus clock, each timebase tick is therefore about one microsecond. A 16-bit down-counter counts those ticks. The counter is reloaded from a preload value, so the timeout delay is the preload value times 33 bus clock periods. The longest delay is about 65 ms.

Each received word restarts the whole timer: the prescaler returns to phase zero and the counter takes the current preload value. When the counter reaches zero, two things happen at once. A sticky timeout flag is set, and a single-cycle interrupt request is issued. The counter then stays at zero until it is reloaded. Clearing the status also reloads the timer. A preload of zero leaves the timer idle.

The enable input freezes the timer without losing its position. After reset the counter starts from a default period of 0x00FF. The block is meant to sit next to a receive FIFO. The FIFO's write strobe drives the data pulse, and the flag and interrupt go to the host interrupt logic.

Top module: `rxidle_watchdog`

## Requirements
- R1: While reset is asserted, timeout_flag and timeout_irq are 0. After reset the counter holds 0x00FF and the prescaler phase is 0. With enable high and no reload, the first timeout therefore comes exactly 255*33 = 8415 clock edges after reset is released.
- R2: After a reload with preload value P > 0 and enable held high, timeout_flag rises exactly at the 33*P-th clock edge after the reload edge, and not one edge earlier.
- R3: timeout_flag stays 1 until the edge that samples clr_status high. A rx_word pulse does not clear it.
- R4: timeout_irq is 1 for exactly one cycle, on the same edge where the counter reaches zero and timeout_flag is set.
- R5: A rx_word pulse reloads the counter from preload and restarts the prescaler at phase 0. A pulse in the middle of a count therefore moves the timeout to 33*P edges after the pulse.
- R6: After an expiry the counter stays at zero. No further timeout_irq is produced until a reload.
- R7: A reload with preload value 0 disables the timeout. No flag and no interrupt follow, however long the wait.
- R8: A change of the preload input during a count has no effect on the running count. It is used only at the next reload.
- R9: While enable is low, the prescaler phase and the counter are frozen. When enable returns, the count resumes where it stopped, so the timeout comes after 33*P enabled edges in total.
- R10: clr_status reloads the counter and restarts the prescaler, just as rx_word does. It clears the flag even when the counter would reach zero on the same edge, and no interrupt is issued on that edge.
- R11: A rx_word pulse sampled on the same edge where the counter would reach zero wins: the timer reloads, and neither flag nor interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_word | input | 1 | One-cycle pulse per received data word; reloads the timer |
| enable | input | 1 | High lets the timer run; low freezes it |
| preload | input | 16 | Timeout period in prescaled ticks; 0 disables |
| clr_status | input | 1 | Clears the timeout flag and reloads the timer |
| timeout_flag | output | 1 | Sticky timeout indication |
| timeout_irq | output | 1 | One-cycle interrupt request at expiry |

## Verification
The timeout is measured exactly at the edge before it and at the edge itself, for several preload values. These are the reset default 255, 10, 4, 1, 2 and 6. An off-by-one in either the prescaler ratio or the counter shows up as a shifted edge. Data pulses come in the middle of a count, and also exactly on the expiry edge; together these separate a true restart from a counter-only reload and settle the priority between reload and expiry. Other cases cover a preload change during a count, an enable gap during a count, a zero preload, and a clear on the expiry edge. Each of these tells apart reload-time sampling, freezing and disabling from their mis-implemented variants. A long wait after an expiry checks that the counter does not wrap.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;

    localparam int unsigned DEF_DIV_RATIO   = 33;
    localparam int unsigned DEF_CNT_W       = 16;
    localparam int unsigned DEF_RST_PRELOAD = 255;

    typedef struct packed {
        logic flag;
        logic irq;
    } stat_t;

endpackage

// File: rtl/rxidle_prescaler.sv
module rxidle_prescaler #(
    parameter int unsigned DIV_RATIO = rxidle_pkg::DEF_DIV_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam int unsigned PRE_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [PRE_W-1:0] LAST_PHASE = PRE_W'(DIV_RATIO - 1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t state_d, state_q;
    logic       tick_c;

    always_comb begin
        state_d = state_q;
        tick_c  = 1'b0;
        if (restart) begin
            state_d.phase = '0;
        end else if (run) begin
            if (state_q.phase == LAST_PHASE) begin
                state_d.phase = '0;
                tick_c        = 1'b1;
            end else begin
                state_d.phase = state_q.phase + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick = tick_c;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(state_q.phase)); // R9

endmodule

// File: rtl/rxidle_downcnt.sv
module rxidle_downcnt #(
    parameter int unsigned CNT_W       = rxidle_pkg::DEF_CNT_W,
    parameter int unsigned RST_PRELOAD = rxidle_pkg::DEF_RST_PRELOAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             nonzero,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_PRELOAD);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       expire_c;

    always_comb begin
        state_d  = state_q;
        expire_c = 1'b0;
        if (reload) begin
            state_d.count = load_val;
        end else if (tick && (state_q.count != '0)) begin
            state_d.count = state_q.count - ONE;
            expire_c      = (state_q.count == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{count: RST_LOAD};
        end else begin
            state_q <= state_d;
        end
    end

    assign nonzero = (state_q.count != '0);
    assign expire  = expire_c;

    AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && (state_q.count == '0)) |=> (state_q.count == '0)); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && (state_q.count != '0)) |=>
            ((state_q.count == $past(state_q.count)) ||
             (state_q.count == ($past(state_q.count) - ONE)))); // R8

endmodule

// File: rtl/rxidle_watchdog.sv
module rxidle_watchdog #(
    parameter int unsigned DIV_RATIO   = rxidle_pkg::DEF_DIV_RATIO,
    parameter int unsigned CNT_W       = rxidle_pkg::DEF_CNT_W,
    parameter int unsigned RST_PRELOAD = rxidle_pkg::DEF_RST_PRELOAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_word,
    input  logic             enable,
    input  logic [CNT_W-1:0] preload,
    input  logic             clr_status,
    output logic             timeout_flag,
    output logic             timeout_irq
);

    import rxidle_pkg::*;

    logic  reload;
    logic  tick;
    logic  nonzero;
    logic  expire;
    logic  run;
    stat_t stat_d, stat_q;

    assign reload = rx_word | clr_status;
    assign run    = enable & nonzero;

    rxidle_prescaler #(
        .DIV_RATIO (DIV_RATIO)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload),
        .run     (run),
        .tick    (tick)
    );

    rxidle_downcnt #(
        .CNT_W       (CNT_W),
        .RST_PRELOAD (RST_PRELOAD)
    ) u_downcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .load_val (preload),
        .tick     (tick),
        .nonzero  (nonzero),
        .expire   (expire)
    );

    always_comb begin
        stat_d     = stat_q;
        stat_d.irq = expire;
        if (clr_status) begin
            stat_d.flag = 1'b0;
        end else if (expire) begin
            stat_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign timeout_flag = stat_q.flag;
    assign timeout_irq  = stat_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |=> !timeout_irq); // R4

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> timeout_flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clr_status) |=> timeout_flag); // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |=> (!timeout_flag && !timeout_irq)); // R10

    AST_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word |=> !timeout_irq); // R11

endmodule

// File: tb/rxidle_watchdog_tb.sv
module rxidle_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_word = 1'b0;
    logic        enable = 1'b1;
    logic [15:0] preload = 16'd5;
    logic        clr_status = 1'b0;
    logic        timeout_flag;
    logic        timeout_irq;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxidle_watchdog u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_word      (rx_word),
        .enable       (enable),
        .preload      (preload),
        .clr_status   (clr_status),
        .timeout_flag (timeout_flag),
        .timeout_irq  (timeout_irq)
    );

    always @(negedge clk) if (rst_n && timeout_irq) irq_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge after the reload edge.
    task automatic pulse(input bit use_clr);
        if (use_clr) clr_status = 1'b1; else rx_word = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_status = 1'b0;
        rx_word    = 1'b0;
    endtask

    task automatic t_reset_default;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 flag in reset", timeout_flag, 0);
        chk("R1 irq in reset", timeout_irq, 0);
        rst_n = 1'b1;
        run(8414);
        chk("R1 no flag one edge early", timeout_flag, 0);
        run(1);
        chk("R1 flag at default period", timeout_flag, 1);
        chk("R4 irq with flag", timeout_irq, 1);
        run(1);
        chk("R4 irq one cycle", timeout_irq, 0);
        chk("R3 flag held", timeout_flag, 1);
    endtask

    task automatic t_hold_zero;
        int base = irq_seen;
        run(600);
        chk("R6 no second irq", irq_seen - base, 0);
        chk("R6 flag still set", timeout_flag, 1);
    endtask

    task automatic t_period;
        preload = 16'd10;
        pulse(1'b1);
        chk("R10 clear drops flag", timeout_flag, 0);
        run(329);
        chk("R2 no flag at 329", timeout_flag, 0);
        run(1);
        chk("R2 flag at 330", timeout_flag, 1);
        chk("R2 irq at 330", timeout_irq, 1);
    endtask

    task automatic t_sticky;
        pulse(1'b0);
        chk("R3 data keeps flag", timeout_flag, 1);
        run(20);
        chk("R3 flag after wait", timeout_flag, 1);
        pulse(1'b1);
        chk("R3 clear releases flag", timeout_flag, 0);
    endtask

    task automatic t_restart;
        preload = 16'd4;
        pulse(1'b1);
        run(100);
        pulse(1'b0);
        run(131);
        chk("R5 restarted no flag at 131", timeout_flag, 0);
        run(1);
        chk("R5 flag 132 after data", timeout_flag, 1);
    endtask

    task automatic t_zero_disable;
        int base;
        preload = 16'd0;
        pulse(1'b1);
        base = irq_seen;
        run(3000);
        chk("R7 zero preload no flag", timeout_flag, 0);
        chk("R7 zero preload no irq", irq_seen - base, 0);
    endtask

    task automatic t_preload_change;
        preload = 16'd6;
        pulse(1'b1);
        run(50);
        preload = 16'd2;
        run(147);
        chk("R8 old period no flag at 197", timeout_flag, 0);
        run(1);
        chk("R8 old period flag at 198", timeout_flag, 1);
        pulse(1'b1);
        run(65);
        chk("R8 new period no flag at 65", timeout_flag, 0);
        run(1);
        chk("R8 new period flag at 66", timeout_flag, 1);
    endtask

    task automatic t_enable_freeze;
        preload = 16'd3;
        pulse(1'b1);
        run(40);
        enable = 1'b0;
        run(200);
        chk("R9 frozen no flag", timeout_flag, 0);
        enable = 1'b1;
        run(58);
        chk("R9 resumed no flag at 98", timeout_flag, 0);
        run(1);
        chk("R9 resumed flag at 99", timeout_flag, 1);
    endtask

    task automatic t_collisions;
        preload = 16'd1;
        pulse(1'b1);
        run(32);
        pulse(1'b0);
        chk("R11 data on expiry no flag", timeout_flag, 0);
        chk("R11 data on expiry no irq", timeout_irq, 0);
        run(32);
        chk("R11 reloaded no flag at 32", timeout_flag, 0);
        run(1);
        chk("R11 reloaded flag at 33", timeout_flag, 1);
        pulse(1'b1);
        run(32);
        pulse(1'b1);
        chk("R10 clear on expiry no flag", timeout_flag, 0);
        chk("R10 clear on expiry no irq", timeout_irq, 0);
        run(33);
        chk("R10 clear restarted period", timeout_flag, 1);
    endtask

    initial begin
        t_reset_default();
        t_hold_zero();
        t_period();
        t_sticky();
        t_restart();
        t_zero_disable();
        t_preload_change();
        t_enable_freeze();
        t_collisions();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule